// File: doc/BRIEF.md
# Watchdog Timer with Early Warning

This block is a watchdog counter that runs on the system clock. Software picks one of four timeout lengths with a 2-bit code and turns the counter on. Software must then pulse a restart strobe often enough to stop the selected interval from running out. If the interval does run out, the block does not reset the system straight away. It first sets a sticky warning flag, which can drive an interrupt. It then waits a fixed warning window and only after that raises a one-clock system reset request. The window gives an interrupt handler time to put the system into a safe state, or to restart the watchdog and cancel the reset.

The interval lengths are powers of two. Each one is a base exponent plus a multiple of a step exponent. The defaults give 2^12, 2^15, 2^18 and 2^21 clocks, with a 512-clock warning window. The interval code, the enable, the interrupt enable and the reset enable are level inputs taken from a control register. The restart and flag-clear inputs are one-clock strobes.

Top module: `wdt_early_warn`

## Requirements
- R1: The interval code on `ival_sel` picks the timeout length. Code 0 gives 2^BASE_LOG2 clocks and each higher code adds STEP_LOG2 to the exponent. With the defaults the codes 00, 01, 10 and 11 give 2^12, 2^15, 2^18 and 2^21 clocks.
- R2: The counter restarts at any clock edge where `en` is low, `restart` is high or `ival_sel` differs from its value at the previous edge. When none of these happens for the next `interval` clock edges, `flag` is high after the last of those edges.
- R3: When the warning window starts, `flag` is set. If `rst_en` is high, `rst_req` is high for exactly one clock, WARN_CLKS clock edges after the edge that set the flag. The counter then starts a new interval from zero.
- R4: While `rst_en` is low, a warning window that runs out produces no `rst_req`. The counter still starts a new interval.
- R5: A `restart` strobe during the warning window ends the window, and no `rst_req` follows from it.
- R6: A change of `ival_sel` restarts the counting, and the new interval length applies from that edge.
- R7: With `en` low the counter stays cleared, no warning window runs and no `rst_req` is produced.
- R8: `flag` stays high until a `flag_clr` strobe. A timeout and a clear at the same edge leave `flag` high.
- R9: `irq` is high exactly when `flag` is high and `irq_en` is high.
- R10: After reset, `flag`, `irq` and `rst_req` are low and the counter starts from zero with interval code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Watchdog enable level |
| ival_sel | input | 2 | Timeout interval code |
| restart | input | 1 | Restart strobe that clears the counter |
| irq_en | input | 1 | Lets the flag through to `irq` |
| rst_en | input | 1 | Allows a reset request when the window runs out |
| flag_clr | input | 1 | Strobe that clears the warning flag |
| irq | output | 1 | Early-warning interrupt |
| flag | output | 1 | Sticky warning flag |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The bench shortens the intervals through the parameters to 64, 256, 1024 and 4096 clocks, with a 16-clock window. It first measures the undisturbed run from enable to flag and from flag to reset request. This separates an off-by-one in the interval compare from one in the window counter. Directed runs then restart inside the window, run with the reset enable off, and hold the flag clear high. These runs separate cancelling a reset from only masking it, and show whether set or clear wins on the flag. A long random run mixes rare restarts, code changes, enable drops and flag clears against a cycle model built from the requirements. This exercises a code change or an enable drop landing inside a window, which the directed runs do not reach.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned NUM_IVALS = 4;

    typedef enum logic [1:0] {
        IV_SHORT  = 2'd0,
        IV_MID_LO = 2'd1,
        IV_MID_HI = 2'd2,
        IV_LONG   = 2'd3
    } wdt_ival_e;

endpackage

// File: rtl/wdt_interval_dec.sv
module wdt_interval_dec
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12,
    parameter int unsigned STEP_LOG2 = 3,
    localparam int unsigned CNT_W    = BASE_LOG2 + (NUM_IVALS - 1) * STEP_LOG2
) (
    input  logic [1:0]       ival_sel,
    output logic [CNT_W-1:0] limit
);

    logic [CNT_W-1:0] lim_tab [NUM_IVALS];

    // terminal count of each interval is its length minus one
    for (genvar k = 0; k < NUM_IVALS; k++) begin : g_lim
        localparam int unsigned EXP = BASE_LOG2 + k * STEP_LOG2;
        assign lim_tab[k] = CNT_W'((64'd1 << EXP) - 64'd1);
    end

    always_comb begin
        limit = lim_tab[ival_sel];
    end

endmodule

// File: rtl/wdt_warn_window.sv
module wdt_warn_window #(
    parameter int unsigned WARN_CLKS = 512,
    localparam int unsigned WW       = (WARN_CLKS > 2) ? $clog2(WARN_CLKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic active,
    output logic expire
);

    typedef struct packed {
        logic          act;
        logic [WW-1:0] wcnt;
    } win_t;

    win_t win_q, win_d;

    always_comb begin
        expire = win_q.act && (win_q.wcnt == WW'(WARN_CLKS - 1));
        active = win_q.act;
        win_d  = win_q;
        if (cancel) begin
            win_d.act  = 1'b0;
            win_d.wcnt = '0;
        end else if (start) begin
            win_d.act  = 1'b1;
            win_d.wcnt = '0;
        end else if (expire) begin
            win_d.act  = 1'b0;
            win_d.wcnt = '0;
        end else if (win_q.act) begin
            win_d.wcnt = win_q.wcnt + WW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // R3: a started window is open on the following cycle
    a_r3_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cancel) |=> active);

    // R5: a cancel closes the window
    a_r5_cancel_closes: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !active);

endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12,
    parameter int unsigned STEP_LOG2 = 3,
    parameter int unsigned WARN_CLKS = 512,
    localparam int unsigned CNT_W    = BASE_LOG2 + (NUM_IVALS - 1) * STEP_LOG2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] ival_sel,
    input  logic       restart,
    input  logic       irq_en,
    input  logic       rst_en,
    input  logic       flag_clr,
    output logic       irq,
    output logic       flag,
    output logic       rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       sel;
        logic             flag;
        logic             rreq;
    } st_t;

    st_t              st_q, st_d;
    logic [CNT_W-1:0] limit;
    logic             win_active;
    logic             win_expire;
    logic             sel_chg;
    logic             reload;
    logic             timeout;

    wdt_interval_dec #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_dec (
        .ival_sel (ival_sel),
        .limit    (limit)
    );

    wdt_warn_window #(
        .WARN_CLKS (WARN_CLKS)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (timeout),
        .cancel (reload),
        .active (win_active),
        .expire (win_expire)
    );

    always_comb begin
        sel_chg = (ival_sel != st_q.sel);
        reload  = !en || restart || sel_chg;
        timeout = !reload && !win_active && (st_q.cnt == limit);

        st_d      = st_q;
        st_d.sel  = ival_sel;
        st_d.rreq = 1'b0;

        if (reload || timeout || win_active) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (win_expire && !reload) begin
            st_d.rreq = rst_en;
        end

        if (timeout) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag    = st_q.flag;
    assign rst_req = st_q.rreq;
    assign irq     = st_q.flag && irq_en;

    // R3: the reset request lasts a single clock
    a_r3_rreq_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4: a reset request needs the reset enable at the edge before it
    a_r4_rreq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(rst_en));

    // R2: a timeout sets the flag
    a_r2_timeout_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> flag);

    // R8: the flag holds until cleared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R5: a restart strobe suppresses the reset request
    a_r5_restart_no_rreq: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !rst_req);

    // R7: disabled means no warning window
    a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!win_active && !rst_req));

endmodule

// File: tb/sim_wdt_early_warn.sv
module sim_wdt_early_warn;

    localparam int  CLK_PERIOD = 10;
    localparam int  B_LOG2     = 6;
    localparam int  S_LOG2     = 2;
    localparam int  WARN       = 16;
    localparam int  WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] ival_sel = 2'd0;
    logic       restart = 1'b0;
    logic       irq_en = 1'b0;
    logic       rst_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq, flag, rst_req;

    int checks = 0;
    int errors = 0;
    string phase = "R10 reset";

    // reference model state
    int   m_left;
    int   m_wleft;
    bit   m_win;
    bit   m_flag;
    bit   m_rreq;
    logic [1:0] m_sel;

    wdt_early_warn #(
        .BASE_LOG2 (B_LOG2),
        .STEP_LOG2 (S_LOG2),
        .WARN_CLKS (WARN)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ival_sel (ival_sel),
        .restart  (restart),
        .irq_en   (irq_en),
        .rst_en   (rst_en),
        .flag_clr (flag_clr),
        .irq      (irq),
        .flag     (flag),
        .rst_req  (rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int ival_len(input logic [1:0] code);
        return 1 << (B_LOG2 + S_LOG2 * int'(code));
    endfunction

    function automatic bit exp_irq(input bit f, input logic ie);
        return f && (ie === 1'b1);
    endfunction

    // cycle model written from the requirements: count down to the timeout
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_left  = ival_len(2'd0);
            m_wleft = 0;
            m_win   = 1'b0;
            m_flag  = 1'b0;
            m_rreq  = 1'b0;
            m_sel   = 2'd0;
        end else begin
            bit tmo;
            tmo    = 1'b0;
            m_rreq = 1'b0;
            if (!en || restart || (ival_sel != m_sel)) begin
                m_left = ival_len(ival_sel);
                m_win  = 1'b0;
            end else if (m_win) begin
                m_wleft = m_wleft - 1;
                if (m_wleft == 0) begin
                    m_win  = 1'b0;
                    m_rreq = rst_en;
                    m_left = ival_len(ival_sel);
                end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    tmo     = 1'b1;
                    m_win   = 1'b1;
                    m_wleft = WARN;
                end
            end
            if (tmo) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            m_sel = ival_sel;
        end
    end

    task automatic chk(input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", phase, what, act, expv, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk("flag (R2/R8)", flag, m_flag);
            chk("rst_req (R3)", rst_req, m_rreq);
            chk("irq (R9)", irq, exp_irq(m_flag, irq_en));
        end
    endtask

    task automatic chk_int(input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, expv);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int k;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        // R10: outputs low in reset
        chk("R10 flag", flag, 1'b0);
        chk("R10 irq", irq, 1'b0);
        chk("R10 rst_req", rst_req, 1'b0);
        rst_n = 1'b1;
        tick();

        // R1 R2: undisturbed run with code 0 takes 64 clocks
        phase = "R1 R2 first interval";
        irq_en = 1'b1;
        rst_en = 1'b1;
        en = 1'b1;
        k = 0;
        do begin tick(); k++; end while (!flag && k < 10000);
        chk_int("R1 clocks to flag", k, 64);

        // R3: reset request WARN clocks after the flag, one clock wide
        phase = "R3 window";
        k = 0;
        do begin tick(); k++; end while (!rst_req && k < 10000);
        chk_int("R3 clocks flag to rst_req", k, WARN);
        tick();
        chk("R3 rst_req pulse width", rst_req, 1'b0);

        // R8: flag clear, then a held clear loses against a timeout
        phase = "R8 set wins";
        flag_clr = 1'b1;
        repeat (80) tick();
        flag_clr = 1'b0;
        tick();

        // R4: no reset request while reset enable is low
        phase = "R4 reset disabled";
        rst_en = 1'b0;
        k = 0;
        repeat (200) begin tick(); if (rst_req) k++; end
        chk_int("R4 reset requests seen", k, 0);
        rst_en = 1'b1;

        // R5: restart inside the window cancels the reset
        phase = "R5 restart in window";
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        restart = 1'b1; tick(); restart = 1'b0;
        do tick(); while (!flag);
        repeat (5) tick();
        restart = 1'b1; tick(); restart = 1'b0;
        k = 0;
        repeat (WARN + 10) begin tick(); if (rst_req) k++; end
        chk_int("R5 reset requests seen", k, 0);

        // R6: code change restarts and applies the longer interval
        phase = "R6 code change";
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        repeat (30) tick();
        ival_sel = 2'd1;
        k = 0;
        do begin tick(); k++; end while (!flag && k < 10000);
        chk_int("R6 clocks to flag after change", k, 257);

        // R7: disable in the window, no reset request
        phase = "R7 disable";
        repeat (4) tick();
        en = 1'b0;
        k = 0;
        repeat (WARN + 300) begin tick(); if (rst_req) k++; end
        chk_int("R7 reset requests seen", k, 0);
        en = 1'b1;

        // R9: interrupt masking
        phase = "R9 mask";
        irq_en = 1'b0;
        repeat (10) tick();
        chk("R9 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        tick();

        // random mix against the model
        phase = "R1 R2 R6 random";
        ival_sel = 2'd3;
        repeat (150000) begin
            tick();
            restart  = ($urandom % 6000) == 0;
            flag_clr = ($urandom % 60) == 0;
            if (($urandom % 5000) == 0) ival_sel = 2'($urandom);
            if (($urandom % 4000) == 0) en = !en;
            if (($urandom % 700) == 0) irq_en = !irq_en;
            if (($urandom % 900) == 0) rst_en = !rst_en;
            if (!en && ($urandom % 20) == 0) en = 1'b1;
        end
        restart = 1'b0;
        flag_clr = 1'b0;
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule